// File: doc/BRIEF.md
# Ready-Busy Wait Timeout Unit

This unit holds a flash command sequencer at a wait-type instruction until the flash device reports ready, or until a programmable time limit runs out, whichever comes first. The sequencer raises a start strobe when it reaches such an instruction. It then stalls for as long as the unit's wait output is high. Instructions that do not wait never raise the strobe, so they pass the unit by.

The time limit is a 4-bit exponent code taken from a control register. The limit is 256 × 2^code local clock cycles, which spans 256 cycles for code 0 to 8,388,608 cycles for code 15. The ready/busy pin is asynchronous. It goes through a two-flop synchronizer, and the unit tests the synchronized level. When the wait ends, a one-cycle done pulse is issued. Alongside it, a flag records whether the wait ended because the time limit ran out.

Top module: `rbw_wait_unit`

## Requirements
- R1: After reset, done_o, timed_out_o and wait_o are all 0.
- R2: With the ready pin held low, done_o is high in exactly the cycle 256 × 2^code clock edges after the edge that accepted the start, and timed_out_o is 1 with it.
- R3: If the ready pin rises between two clock edges and the wait is still active, done_o is high after the third edge that follows the rise, and timed_out_o is 0.
- R4: done_o is high for exactly one cycle per completed wait.
- R5: If the synchronized ready level and the terminal count occur on the same edge, the wait ends as ready, with timed_out_o = 0.
- R6: The timeout code is captured at the accepted start. Changing tmo_code_i during a wait does not change when that wait ends.
- R7: A start strobe that arrives while a wait is active is ignored. The wait keeps its original end time and produces only one done pulse.
- R8: wait_o is high from the edge that accepts a start up to the edge that raises done_o, and it is low in the done cycle.
- R9: timed_out_o keeps the result of the last completed wait until the next wait completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe from the sequencer for a wait-type instruction |
| tmo_code_i | input | 4 | Timeout exponent; the limit is 256 << code cycles |
| rb_pin_i | input | 1 | Asynchronous flash ready/busy pin; high means ready |
| done_o | output | 1 | One-cycle pulse when the wait ends |
| timed_out_o | output | 1 | 1 when the last wait ended by timeout, 0 when it ended by ready |
| wait_o | output | 1 | High while a wait is active; the sequencer stalls while it is high |

## Verification
The two events that can coincide are the synchronized ready level arriving and the counter reaching its terminal count. The bench causes this by raising the pin exactly 254 edges after a code-0 start, so that both land on edge 256. It also raises the pin one edge earlier and one edge later. The expected end cycle and flag for each case come from a bench function that takes the earlier of the ready time and the limit, and gives ready the win on a tie.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned BASE_LOG = 8;
  localparam int unsigned CNT_W    = BASE_LOG + (1 << CODE_W) - 1 + 1;

  typedef enum logic {
    END_READY   = 1'b0,
    END_TIMEOUT = 1'b1
  } end_cause_e;
endpackage

// File: rtl/rbw_sync.sv
module rbw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rbw_limit.sv
module rbw_limit #(
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned BASE_LOG = 8,
  parameter int unsigned CNT_W    = 24
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  limit_o
);
  localparam int unsigned NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] table_w [NCODES];

  generate
    for (genvar c = 0; c < NCODES; c++) begin : g_code
      assign table_w[c] = CNT_W'((64'd1 << (BASE_LOG + c)) - 64'd1);
    end
  endgenerate

  assign limit_o = table_w[code_i];
endmodule

// File: rtl/rbw_timer.sv
module rbw_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             at_limit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == limit_i);

  // R2: a running count never passes the terminal value
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q <= limit_i);

  // R2: counting advances by one per enabled cycle
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rbw_wait_unit.sv
module rbw_wait_unit
  import rbw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] tmo_code_i,
  input  logic              rb_pin_i,
  output logic              done_o,
  output logic              timed_out_o,
  output logic              wait_o
);
  logic              active_q;
  logic [CODE_W-1:0] code_q;
  logic              done_q;
  end_cause_e        cause_q;
  logic              rdy_w;
  logic              at_limit_w;
  logic [CNT_W-1:0]  limit_w;

  rbw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (rb_pin_i),
    .sync_o  (rdy_w)
  );

  rbw_limit #(.CODE_W(CODE_W), .BASE_LOG(BASE_LOG), .CNT_W(CNT_W)) u_limit (
    .code_i  (code_q),
    .limit_o (limit_w)
  );

  rbw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!active_q),
    .en_i       (active_q && !rdy_w && !at_limit_w),
    .limit_i    (limit_w),
    .at_limit_o (at_limit_w)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      code_q   <= '0;
      done_q   <= 1'b0;
      cause_q  <= END_READY;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          code_q   <= tmo_code_i;
        end
      end else if (rdy_w) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
        cause_q  <= END_READY;
      end else if (at_limit_w) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
        cause_q  <= END_TIMEOUT;
      end
    end
  end

  assign done_o      = done_q;
  assign timed_out_o = (cause_q == END_TIMEOUT);
  assign wait_o      = active_q;

  // R4: completion is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3 and R5: a synchronized ready level ends the wait as ready, even at terminal count
  assert_ready_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && rdy_w) |=> (done_o && !timed_out_o && !wait_o));

  // R2: terminal count with no ready ends the wait as timeout
  assert_timeout_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && !rdy_w && at_limit_w) |=> (done_o && timed_out_o));

  // R6 and R7: the captured code does not move during a wait, whatever arrives
  assert_code_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |=> $stable(code_q));

  // R7: a start during a wait neither ends nor restarts it
  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && start_i && !rdy_w && !at_limit_w) |=> (wait_o && !done_o));

  // R9: the cause flag only changes together with a done pulse
  assert_flag_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(timed_out_o));
endmodule

// File: tb/rbw_wait_unit_tb.sv
module rbw_wait_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] code = 4'd0;
  logic       rb = 1'b0;
  logic       done, tmo, wt;

  int unsigned cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rbw_wait_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tmo_code_i(code),
    .rb_pin_i(rb), .done_o(done), .timed_out_o(tmo), .wait_o(wt)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lim(input int c);
    return longint'(256) << c;
  endfunction

  // rb rises d edges after the start edge (d<0: never); ready end at d+2, ties to ready
  function automatic longint exp_rel(input int c, input int d);
    if (d >= 0 && longint'(d + 2) <= lim(c)) return d + 2;
    return lim(c);
  endfunction

  function automatic bit exp_tmo(input int c, input int d);
    return !(d >= 0 && longint'(d + 2) <= lim(c));
  endfunction

  // runs one wait; optional mid-wait code change and extra start at edge `poke`
  task automatic run_wait(input string req, input int c, input int d,
                          input int poke, input bit chg_code);
    int unsigned s;
    int unsigned dcyc;
    bit saw_wait = 1'b1;
    @(negedge clk);
    code = 4'(c);
    start = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (d >= 0 && cyc == s + 32'(d) - 1) rb = 1'b1;
      if (poke > 0 && cyc == s + 32'(poke)) begin
        start = 1'b1;
        if (chg_code) code = 4'd15;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (done) break;
      if (!wt) saw_wait = 1'b0;
    end
    dcyc = cyc;
    start = 1'b0;
    check({req, " end cycle"}, longint'(dcyc - s), exp_rel(c, d));
    check({req, " timeout flag"}, tmo, exp_tmo(c, d));
    check("R8 wait high during wait", saw_wait, 1);
    check("R8 wait low at done", wt, 0);
    @(negedge clk);
    check("R4 done single cycle", done, 0);
    check("R9 flag held", tmo, exp_tmo(c, d));
    rb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 done at reset", done, 0);
    check("R1 flag at reset", tmo, 0);
    check("R1 wait at reset", wt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 wait idle after reset", wt, 0);

    run_wait("R2 code0 timeout", 0, -1, 0, 1'b0);
    run_wait("R2 code3 timeout", 3, -1, 0, 1'b0);
    run_wait("R3 ready early", 2, 1, 0, 1'b0);
    run_wait("R3 ready mid", 1, 100, 0, 1'b0);
    run_wait("R5 tie ready wins", 0, 254, 0, 1'b0);
    run_wait("R5 ready one before", 0, 253, 0, 1'b0);
    run_wait("R5 ready one late", 0, 255, 0, 1'b0);
    run_wait("R6 code change mid wait", 1, -1, 40, 1'b1);
    run_wait("R7 start during wait", 2, -1, 10, 1'b0);
    run_wait("R7 start during ready wait", 3, 50, 20, 1'b0);
    run_wait("R2 code7 timeout", 7, -1, 0, 1'b0);

    for (int i = 0; i < 30; i++) begin
      int c = int'($urandom_range(0, 3));
      int d = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(1, 2200));
      run_wait("R3 random wait", c, d, 0, 1'b0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule